// File: doc/BRIEF.md
# Byte-Lane Dual-Port Memory

This block is a synchronous two-port memory of 8192 sixteen-bit words. A left port and a right port each carry their own enable, write strobe, output enable, two byte-lane selects, a semaphore select, a 13-bit address, a write-data bus, a read-data bus and one output-valid bit per byte lane. Both ports run on one clock but are otherwise independent. Either one may read or write any word in any cycle, and both may read the same word at once.

Each port's control lines are decoded into one of four actions: deselect, a byte-masked write, a byte-masked read, or a read with the outputs disabled. A byte lane that is not driven shows a low valid bit and zero data. A cycle with the semaphore select active never touches the array. The only result of such a cycle is a one-cycle marker that a separate semaphore unit can take up. Read results arrive one clock after the request. All control inputs are active high, and `we` high means write.

Top module: `dpm_bytelane_top`

## Requirements
- R1: The array holds 8192 words of 16 bits addressed by 13 bits. A word written on either port reads back unchanged on either port.
- R2: Both ports can read the same address in the same cycle, and each port gets the full stored word.
- R3: With `ce` low, a port stores nothing, and on the next cycle its `rvalid` is 2'b00 and its `rdata` is zero, whatever its other inputs are.
- R4: With `ce` high and both `ub` and `lb` low, the port neither stores nor drives any lane.
- R5: A write (`ce`=1, `we`=1, `sem`=0) stores bits 15:8 only when `ub`=1 and bits 7:0 only when `lb`=1. `oe` has no effect on a write, and no lane is valid on the cycle after a write.
- R6: A read (`ce`=1, `we`=0, `oe`=1, `sem`=0) sets `rvalid[1]`=`ub` and `rvalid[0]`=`lb` one cycle later, with the stored byte on each valid lane and zero on each invalid lane.
- R7: A read with `oe`=0 leaves both lanes invalid with zero data.
- R8: With `ce`=1 and `sem`=1, the array is neither read nor written, and `sem_hit` is 1 on the following cycle. In every other case `sem_hit` is 0.
- R9: A read on one port and a write to the same address on the other port in the same cycle return the data held before the write.
- R10: If both ports write the same address in the same cycle, the left port's bytes are stored on lanes both ports select, and each port's bytes are stored on lanes only that port selects.
- R11: A synchronous active-high `rst` clears `rvalid`, `rdata` and `sem_hit` on both ports. The array contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous reset, active high |
| l_ce | input | 1 | Left port enable |
| l_we | input | 1 | Left write strobe (1 = write, 0 = read) |
| l_oe | input | 1 | Left output enable |
| l_ub | input | 1 | Left upper byte select (bits 15:8) |
| l_lb | input | 1 | Left lower byte select (bits 7:0) |
| l_sem | input | 1 | Left semaphore select |
| l_addr | input | 13 | Left word address |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data, zero on invalid lanes |
| l_rvalid | output | 2 | Left lane valid, bit 1 = upper, bit 0 = lower |
| l_sem_hit | output | 1 | Left semaphore-cycle marker |
| r_ce | input | 1 | Right port enable |
| r_we | input | 1 | Right write strobe |
| r_oe | input | 1 | Right output enable |
| r_ub | input | 1 | Right upper byte select |
| r_lb | input | 1 | Right lower byte select |
| r_sem | input | 1 | Right semaphore select |
| r_addr | input | 13 | Right word address |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data |
| r_rvalid | output | 2 | Right lane valid |
| r_sem_hit | output | 1 | Right semaphore-cycle marker |

## Verification
The bench aims at same-address traffic from both ports. In a read-against-write cycle, a design that forwards the new data instead of returning the old word would fail. In a write-against-write cycle with partly overlapping lanes, swapped priority or a lost byte of the other port shows up on readback. It also goes after the cases where lines must be ignored: a write or enable issued while `ce` is low or `sem` is high, and `oe` toggling during a write. A leaky decode would change later readback or raise a lane valid. A mixed random phase on a small address window exercises the upper and lower lane masks separately, so a design that swapped or merged lanes would put bytes on the wrong half.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  localparam int DPM_LANES = 2;

  typedef struct packed {
    logic [DPM_LANES-1:0] wr;
    logic [DPM_LANES-1:0] rd;
    logic                 sem;
  } dpm_ctl_t;
endpackage

// File: rtl/dpm_port_decode.sv
module dpm_port_decode
  import dpm_pkg::*;
(
  input  logic     ce,
  input  logic     we,
  input  logic     oe,
  input  logic     ub,
  input  logic     lb,
  input  logic     sem,
  output dpm_ctl_t ctl
);
  logic array_cyc;

  always_comb begin
    array_cyc = ce & ~sem;
    ctl.wr    = (array_cyc & we) ? {ub, lb} : '0;
    ctl.rd    = (array_cyc & ~we & oe) ? {ub, lb} : '0;
    ctl.sem   = ce & sem;
  end
endmodule

// File: rtl/dpm_lane_ram.sv
module dpm_lane_ram #(
  parameter int ADDR_W = 13,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_wr,
  input  logic              a_rd,
  input  logic [LANE_W-1:0] a_wdata,
  output logic [LANE_W-1:0] a_q,
  output logic              a_vld,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_wr,
  input  logic              b_rd,
  input  logic [LANE_W-1:0] b_wdata,
  output logic [LANE_W-1:0] b_q,
  output logic              b_vld
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  // Port b is written first, so port a wins on a shared address.
  always_ff @(posedge clk) begin
    if (b_wr) mem[b_addr] <= b_wdata;
    if (a_wr) mem[a_addr] <= a_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= '0;
      a_vld <= 1'b0;
      b_q   <= '0;
      b_vld <= 1'b0;
    end else begin
      a_vld <= a_rd;
      b_vld <= b_rd;
      a_q   <= a_rd ? mem[a_addr] : '0;
      b_q   <= b_rd ? mem[b_addr] : '0;
    end
  end

  // R6
  lane_mask_a_chk: assert property (@(posedge clk) disable iff (rst)
    !a_vld |-> (a_q == '0));
  // R6
  lane_mask_b_chk: assert property (@(posedge clk) disable iff (rst)
    !b_vld |-> (b_q == '0));
endmodule

// File: rtl/dpm_bytelane_top.sv
module dpm_bytelane_top
  import dpm_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANE_W * DPM_LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_ce,
  input  logic              l_we,
  input  logic              l_oe,
  input  logic              l_ub,
  input  logic              l_lb,
  input  logic              l_sem,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic [DPM_LANES-1:0] l_rvalid,
  output logic              l_sem_hit,
  input  logic              r_ce,
  input  logic              r_we,
  input  logic              r_oe,
  input  logic              r_ub,
  input  logic              r_lb,
  input  logic              r_sem,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic [DPM_LANES-1:0] r_rvalid,
  output logic              r_sem_hit
);
  dpm_ctl_t l_ctl, r_ctl;

  dpm_port_decode u_dec_l (
    .ce(l_ce), .we(l_we), .oe(l_oe), .ub(l_ub), .lb(l_lb), .sem(l_sem), .ctl(l_ctl)
  );
  dpm_port_decode u_dec_r (
    .ce(r_ce), .we(r_we), .oe(r_oe), .ub(r_ub), .lb(r_lb), .sem(r_sem), .ctl(r_ctl)
  );

  for (genvar g = 0; g < DPM_LANES; g++) begin : g_lane
    dpm_lane_ram #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_ram (
      .clk    (clk),
      .rst    (rst),
      .a_addr (l_addr),
      .a_wr   (l_ctl.wr[g]),
      .a_rd   (l_ctl.rd[g]),
      .a_wdata(l_wdata[g*LANE_W +: LANE_W]),
      .a_q    (l_rdata[g*LANE_W +: LANE_W]),
      .a_vld  (l_rvalid[g]),
      .b_addr (r_addr),
      .b_wr   (r_ctl.wr[g]),
      .b_rd   (r_ctl.rd[g]),
      .b_wdata(r_wdata[g*LANE_W +: LANE_W]),
      .b_q    (r_rdata[g*LANE_W +: LANE_W]),
      .b_vld  (r_rvalid[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      l_sem_hit <= 1'b0;
      r_sem_hit <= 1'b0;
    end else begin
      l_sem_hit <= l_ctl.sem;
      r_sem_hit <= r_ctl.sem;
    end
  end

  // R3
  desel_l_chk: assert property (@(posedge clk) disable iff (rst)
    !l_ce |=> (l_rvalid == '0) && !l_sem_hit);
  // R3
  desel_r_chk: assert property (@(posedge clk) disable iff (rst)
    !r_ce |=> (r_rvalid == '0) && !r_sem_hit);
  // R5
  wr_quiet_l_chk: assert property (@(posedge clk) disable iff (rst)
    (l_ce && l_we) |=> (l_rvalid == '0));
  // R6
  rd_lanes_l_chk: assert property (@(posedge clk) disable iff (rst)
    (l_ce && !l_we && l_oe && !l_sem) |=> (l_rvalid == $past({l_ub, l_lb})));
  // R6
  rd_lanes_r_chk: assert property (@(posedge clk) disable iff (rst)
    (r_ce && !r_we && r_oe && !r_sem) |=> (r_rvalid == $past({r_ub, r_lb})));
  // R7
  oe_off_r_chk: assert property (@(posedge clk) disable iff (rst)
    (r_ce && !r_we && !r_oe) |=> (r_rvalid == '0));
  // R8
  sem_block_l_chk: assert property (@(posedge clk) disable iff (rst)
    (l_ce && l_sem) |=> l_sem_hit && (l_rvalid == '0));
  // R8
  sem_block_r_chk: assert property (@(posedge clk) disable iff (rst)
    (r_ce && r_sem) |=> r_sem_hit && (r_rvalid == '0));
endmodule

// File: tb/dpm_bytelane_top_tb.sv
`timescale 1ns/1ps
module dpm_bytelane_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic l_ce, l_we, l_oe, l_ub, l_lb, l_sem;
  logic r_ce, r_we, r_oe, r_ub, r_lb, r_sem;
  logic [12:0] l_addr, r_addr;
  logic [15:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic [1:0]  l_rvalid, r_rvalid;
  logic        l_sem_hit, r_sem_hit;

  dpm_bytelane_top u_dut (
    .clk(clk), .rst(rst),
    .l_ce(l_ce), .l_we(l_we), .l_oe(l_oe), .l_ub(l_ub), .l_lb(l_lb), .l_sem(l_sem),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rvalid(l_rvalid),
    .l_sem_hit(l_sem_hit),
    .r_ce(r_ce), .r_we(r_we), .r_oe(r_oe), .r_ub(r_ub), .r_lb(r_lb), .r_sem(r_sem),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rvalid(r_rvalid),
    .r_sem_hit(r_sem_hit)
  );

  logic [15:0] model [8192];
  int n_chk = 0;
  int n_fail = 0;
  int n_coll = 0;

  task automatic chk(input bit ok, input string tag, input logic [18:0] act, input logic [18:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] wr_of(input logic ce, we, sem, ub, lb);
    return (ce && !sem && we) ? {ub, lb} : 2'b00;
  endfunction

  function automatic logic [1:0] rd_of(input logic ce, we, oe, sem, ub, lb);
    return (ce && !sem && !we && oe) ? {ub, lb} : 2'b00;
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw, input logic [1:0] m);
    return {m[1] ? nw[15:8] : old[15:8], m[0] ? nw[7:0] : old[7:0]};
  endfunction

  task automatic setl(input logic ce, we, oe, ub, lb, sem, input logic [12:0] a, input logic [15:0] d);
    l_ce = ce; l_we = we; l_oe = oe; l_ub = ub; l_lb = lb; l_sem = sem; l_addr = a; l_wdata = d;
  endtask

  task automatic setr(input logic ce, we, oe, ub, lb, sem, input logic [12:0] a, input logic [15:0] d);
    r_ce = ce; r_we = we; r_oe = oe; r_ub = ub; r_lb = lb; r_sem = sem; r_addr = a; r_wdata = d;
  endtask

  // Inputs already set (after a negedge). Computes expectation, clocks, compares.
  task automatic step(input string tag);
    logic [1:0]  lw, lr, rw, rr;
    logic [15:0] ld, rd;
    logic [18:0] le, re;
    lw = wr_of(l_ce, l_we, l_sem, l_ub, l_lb);
    rw = wr_of(r_ce, r_we, r_sem, r_ub, r_lb);
    lr = rd_of(l_ce, l_we, l_oe, l_sem, l_ub, l_lb);
    rr = rd_of(r_ce, r_we, r_oe, r_sem, r_ub, r_lb);
    ld = model[l_addr] & {{8{lr[1]}}, {8{lr[0]}}};
    rd = model[r_addr] & {{8{rr[1]}}, {8{rr[0]}}};
    le = {l_ce && l_sem, lr, ld};
    re = {r_ce && r_sem, rr, rd};
    if (lw != 2'b00 && rw != 2'b00 && l_addr == r_addr) n_coll++;
    if (rw != 2'b00) model[r_addr] = merge(model[r_addr], r_wdata, rw);
    if (lw != 2'b00) model[l_addr] = merge(model[l_addr], l_wdata, lw);
    @(posedge clk);
    @(negedge clk);
    chk({l_sem_hit, l_rvalid, l_rdata} === le, {tag, " left"}, {l_sem_hit, l_rvalid, l_rdata}, le);
    chk({r_sem_hit, r_rvalid, r_rdata} === re, {tag, " right"}, {r_sem_hit, r_rvalid, r_rdata}, re);
  endtask

  task automatic idle();
    setl(0, 0, 0, 0, 0, 0, '0, '0);
    setr(0, 0, 0, 0, 0, 0, '0, '0);
  endtask

  task automatic rd_both(input logic [12:0] la, input logic [12:0] ra, input string tag);
    setl(1, 0, 1, 1, 1, 0, la, '0);
    setr(1, 0, 1, 1, 1, 0, ra, '0);
    step(tag);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8192; i++) model[i] = '0;
    // R11: reset holds outputs low even with reads and semaphore requests pending
    setl(1, 0, 1, 1, 1, 0, 13'd0, '0);
    setr(1, 0, 1, 1, 1, 1, 13'd0, '0);
    repeat (3) @(negedge clk);
    chk({l_sem_hit, l_rvalid, l_rdata} === 19'd0, "R11 reset left", {l_sem_hit, l_rvalid, l_rdata}, 19'd0);
    chk({r_sem_hit, r_rvalid, r_rdata} === 19'd0, "R11 reset right", {r_sem_hit, r_rvalid, r_rdata}, 19'd0);
    rst = 1'b0;

    // R1: prefill the low window and the top word
    for (int i = 0; i < 16; i++) begin
      setl(1, 1, 0, 1, 1, 0, 13'(i), 16'(16'h1000 + i * 16'h0111));
      setr(1, 1, 1, 1, 1, 0, 13'(8191 - i), 16'(16'hF000 - i));
      step("R1 fill");
    end
    rd_both(13'd8191, 13'd5, "R1 readback cross");
    setl(0, 0, 0, 0, 0, 0, '0, '0);
    setr(1, 0, 1, 1, 1, 0, 13'd8191, '0);
    step("R1 top word right");

    // R2: same address both ports
    rd_both(13'd7, 13'd7, "R2 shared read");

    // R3: deselected write must not store
    setl(0, 1, 1, 1, 1, 0, 13'd3, 16'hDEAD);
    setr(0, 0, 1, 1, 1, 0, 13'd3, 16'h0);
    step("R3 deselect");
    rd_both(13'd3, 13'd3, "R3 readback");

    // R4: no byte selected
    setl(1, 1, 0, 0, 0, 0, 13'd4, 16'hAAAA);
    setr(1, 0, 1, 0, 0, 0, 13'd4, 16'h0);
    step("R4 no lanes");
    rd_both(13'd4, 13'd4, "R4 readback");

    // R5: lower-only write with oe high, upper-only write with oe low
    setl(1, 1, 1, 0, 1, 0, 13'd6, 16'h55CC);
    setr(1, 1, 0, 1, 0, 0, 13'd8, 16'h77EE);
    step("R5 byte write");
    rd_both(13'd6, 13'd8, "R5 readback");

    // R6: single-lane reads
    setl(1, 0, 1, 1, 0, 0, 13'd9, '0);
    setr(1, 0, 1, 0, 1, 0, 13'd9, '0);
    step("R6 lane read");

    // R7: output disable
    setl(1, 0, 0, 1, 1, 0, 13'd9, '0);
    setr(1, 0, 0, 1, 0, 0, 13'd2, '0);
    step("R7 oe off");

    // R8: semaphore cycles do not touch the array
    setl(1, 1, 1, 1, 1, 1, 13'd10, 16'hBAD0);
    setr(1, 0, 1, 1, 1, 1, 13'd10, '0);
    step("R8 sem");
    rd_both(13'd10, 13'd10, "R8 readback");

    // R9: read against write, same address
    setl(1, 0, 1, 1, 1, 0, 13'd11, '0);
    setr(1, 1, 0, 1, 1, 0, 13'd11, 16'h9A9A);
    step("R9 old data");
    rd_both(13'd11, 13'd11, "R9 new data");

    // R10: write against write, partial overlap
    setl(1, 1, 0, 1, 1, 0, 13'd12, 16'h1122);
    setr(1, 1, 0, 1, 0, 0, 13'd12, 16'h3344);
    step("R10 collide upper");
    setl(1, 1, 0, 1, 0, 0, 13'd13, 16'h5566);
    setr(1, 1, 0, 0, 1, 0, 13'd13, 16'h7788);
    step("R10 disjoint lanes");
    rd_both(13'd12, 13'd13, "R10 readback");

    // Random mix on a small window (R6 masking under load)
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      setl(a[0] | a[1], a[2] & a[3], a[4], a[5], a[6], a[7] & a[8] & a[9], 13'(a[13:10]), 16'($urandom));
      setr(b[0] | b[1], b[2] & b[3], b[4], b[5], b[6], b[7] & b[8] & b[9], 13'(b[13:10]), 16'($urandom));
      step("R6 random");
    end
    idle();
    step("R3 idle");
    $display("write collisions seen: %0d", n_coll);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule